// File: doc/BRIEF.md
# NAND Read Prefetch Engine

This block moves a programmed number of bytes from a byte-wide NAND data stream into a 64-byte on-chip FIFO, on behalf of one chosen chip select. Software programs a byte count and a configuration word over a small register bus, then writes the control register to launch the run. The engine takes bytes from the NAND side with a valid/ready handshake until the count is spent, and stalls whenever the FIFO is full.

The host drains the FIFO through a data register. Each read returns one 32-bit word that holds four bytes. A status register shows how many bytes are still to be fetched and how many bytes the FIFO holds. A threshold flag tells the host when enough data has built up to make a burst of reads worthwhile. Configuration and count writes are refused while a run is active. The run ends on its own once every byte has been fetched and drained, or at once when software writes zero to the control register.

Top module: `nand_prefetch`

## Requirements
- R1: After reset, the control, configuration, count and status registers all read 0, `busy` is 0 and `nand_ready` is 0.
- R2: The configuration register (address 0) holds the write-post flag in bit 0, the enable in bit 7, the threshold in bits 14:8 and the chip select in bits 26:24. A configuration write whose threshold field is above 64 leaves the register unchanged. A threshold of exactly 64 is accepted.
- R3: A NAND byte is taken on every cycle where `nand_valid` and `nand_ready` are both high, and each byte taken lowers the remaining count by one. The status register (address 3) reports the remaining count in bits 13:0 and the FIFO fill in bytes in bits 30:24.
- R4: A read of the data register (address 4) with at least 4 bytes in the FIFO returns the oldest four bytes, packed little-endian (oldest byte in bits 7:0), and removes them from the FIFO.
- R5: A data read with fewer than 4 bytes in the FIFO returns 0 and leaves the fill unchanged.
- R6: While the FIFO holds 64 bytes, `nand_ready` is low, and neither the fill nor the remaining count changes while `nand_valid` is held high.
- R7: A running engine clears its control bit, and `busy` falls, the cycle after the remaining count is 0 and the FIFO is empty. It stays busy while any bytes remain in the FIFO.
- R8: While `busy` is high, writes to the configuration register and to the count register (address 1) are ignored, and `nand_cs` holds the configured chip select.
- R9: Writing 1 to the control register (address 2) starts a run only if the engine is idle, the enable bit is set and the write-post flag is clear. In any other case the engine stays idle.
- R10: Writing 0 to the control register stops a run at once, empties the FIFO and drops `nand_ready`.
- R11: `thr_hit` is high while the engine is running and the FIFO fill is at or above the configured threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at the data address) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| nand_valid | input | 1 | A NAND byte is offered |
| nand_data | input | 8 | NAND byte |
| nand_ready | output | 1 | The engine takes the offered byte |
| nand_cs | output | 3 | Chip select of the configured device |
| busy | output | 1 | A run is active |
| fifo_fill | output | 7 | FIFO occupancy in bytes |
| remain | output | 14 | Bytes still to be fetched |
| thr_hit | output | 1 | FIFO fill has reached the threshold |

## Verification
The hardest state to reach is a full FIFO with bytes still owed by the NAND side. Only here do backpressure and the refusal of new bytes matter. The bench gets there with a count of 100 and no host reads until 64 bytes have arrived, then holds `nand_valid` high for several stalled cycles. It then drains and refills the FIFO in interleaved bursts, so the read pointer wraps while writes continue. A second hard case is a count that is not a multiple of four. In that run the leftover bytes keep the engine busy, and only the abort path releases it.

// File: rtl/nprf_pkg.sv
package nprf_pkg;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_CFG  = 3'd0,
        RA_CNT  = 3'd1,
        RA_CTRL = 3'd2,
        RA_STAT = 3'd3,
        RA_DATA = 3'd4
    } reg_addr_e;

    // configuration field positions (software-visible layout)
    localparam int CFG_WPOST_BIT = 0;
    localparam int CFG_EN_BIT    = 7;
    localparam int CFG_THR_LO    = 8;
    localparam int CFG_CS_LO     = 24;
    // status field positions
    localparam int STAT_FILL_LO  = 24;
    // bytes per host word
    localparam int WORD_BYTES    = 4;
endpackage

// File: rtl/nprf_fifo.sv
module nprf_fifo #(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [7:0]                 push_byte,
    input  logic                       pop,
    output logic [31:0]                word,
    output logic [$clog2(DEPTH):0]     fill
);
    localparam int AW     = $clog2(DEPTH);
    localparam int FILL_W = AW + 1;

    typedef struct packed {
        logic [AW-1:0]     wp;
        logic [AW-1:0]     rp;
        logic [FILL_W-1:0] fill;
    } ptr_t;

    ptr_t       ptr_d, ptr_q;
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        mem_d = mem_q;
        if (push) begin
            mem_d[ptr_q.wp] = push_byte;
            ptr_d.wp        = ptr_q.wp + AW'(1);
        end
        if (pop) begin
            ptr_d.rp = ptr_q.rp + AW'(nprf_pkg::WORD_BYTES);
        end
        ptr_d.fill = ptr_q.fill + FILL_W'(push)
                   - (pop ? FILL_W'(nprf_pkg::WORD_BYTES) : FILL_W'(0));
        if (flush) begin
            ptr_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    for (genvar k = 0; k < nprf_pkg::WORD_BYTES; k++) begin : g_lane
        assign word[8*k +: 8] = mem_q[ptr_q.rp + AW'(k)];
    end

    assign fill = ptr_q.fill;
endmodule

// File: rtl/nprf_regs.sv
module nprf_regs #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 14,
    parameter int CS_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [nprf_pkg::REG_ADDR_W-1:0] reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    input  logic                        nand_valid,
    output logic                        nand_ready,
    input  logic [$clog2(DEPTH):0]      fill,
    input  logic [31:0]                 fifo_word,
    output logic                        push,
    output logic                        pop,
    output logic                        flush,
    output logic                        run,
    output logic [CS_W-1:0]             cs,
    output logic [CNT_W-1:0]            remain,
    output logic                        thr_hit
);
    import nprf_pkg::*;

    localparam int FILL_W = $clog2(DEPTH) + 1;
    localparam int THR_W  = FILL_W;

    typedef struct packed {
        logic             run;
        logic             wpost;
        logic             en;
        logic [THR_W-1:0] thr;
        logic [CS_W-1:0]  cs;
        logic [CNT_W-1:0] remain;
    } st_t;

    st_t st_d, st_q;

    logic             wr_cfg, wr_cnt, wr_ctrl, rd_data;
    logic [THR_W-1:0] thr_field;
    logic             has_word;

    assign wr_cfg    = reg_wr && (reg_addr == RA_CFG);
    assign wr_cnt    = reg_wr && (reg_addr == RA_CNT);
    assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
    assign rd_data   = reg_rd && (reg_addr == RA_DATA);
    assign thr_field = reg_wdata[CFG_THR_LO +: THR_W];
    assign has_word  = fill >= FILL_W'(WORD_BYTES);

    assign nand_ready = st_q.run && (st_q.remain != '0) && (fill < FILL_W'(DEPTH));
    assign push       = nand_ready && nand_valid;
    assign pop        = rd_data && has_word;
    assign flush      = wr_ctrl && !reg_wdata[0];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.remain = st_q.remain - CNT_W'(1);
        end
        if (st_q.run && (st_q.remain == '0) && (fill == '0)) begin
            st_d.run = 1'b0;
        end
        if (wr_cfg && !st_q.run && (int'(thr_field) <= DEPTH)) begin
            st_d.wpost = reg_wdata[CFG_WPOST_BIT];
            st_d.en    = reg_wdata[CFG_EN_BIT];
            st_d.thr   = thr_field;
            st_d.cs    = reg_wdata[CFG_CS_LO +: CS_W];
        end
        if (wr_cnt && !st_q.run) begin
            st_d.remain = reg_wdata[CNT_W-1:0];
        end
        if (wr_ctrl) begin
            if (!reg_wdata[0]) begin
                st_d.run = 1'b0;
            end else if (!st_q.run && st_q.en && !st_q.wpost) begin
                st_d.run = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CFG: begin
                reg_rdata[CFG_WPOST_BIT]        = st_q.wpost;
                reg_rdata[CFG_EN_BIT]           = st_q.en;
                reg_rdata[CFG_THR_LO +: THR_W]  = st_q.thr;
                reg_rdata[CFG_CS_LO +: CS_W]    = st_q.cs;
            end
            RA_CNT:  reg_rdata[CNT_W-1:0] = st_q.remain;
            RA_CTRL: reg_rdata[0]         = st_q.run;
            RA_STAT: begin
                reg_rdata[CNT_W-1:0]             = st_q.remain;
                reg_rdata[STAT_FILL_LO +: FILL_W] = fill;
            end
            RA_DATA: reg_rdata = has_word ? fifo_word : '0;
            default: reg_rdata = '0;
        endcase
    end

    assign run     = st_q.run;
    assign cs      = st_q.cs;
    assign remain  = st_q.remain;
    assign thr_hit = st_q.run && (fill >= st_q.thr);
endmodule

// File: rtl/nand_prefetch.sv
module nand_prefetch #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 14,
    parameter int CS_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [2:0]                    reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic                          nand_valid,
    input  logic [7:0]                    nand_data,
    output logic                          nand_ready,
    output logic [CS_W-1:0]               nand_cs,
    output logic                          busy,
    output logic [$clog2(DEPTH):0]        fifo_fill,
    output logic [CNT_W-1:0]              remain,
    output logic                          thr_hit
);
    logic        push, pop, flush;
    logic [31:0] fifo_word;

    nprf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_byte (nand_data),
        .pop       (pop),
        .word      (fifo_word),
        .fill      (fifo_fill)
    );

    nprf_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CS_W(CS_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .nand_valid (nand_valid),
        .nand_ready (nand_ready),
        .fill       (fifo_fill),
        .fifo_word  (fifo_word),
        .push       (push),
        .pop        (pop),
        .flush      (flush),
        .run        (busy),
        .cs         (nand_cs),
        .remain     (remain),
        .thr_hit    (thr_hit)
    );
endmodule

// File: rtl/nand_prefetch_chk.sv
module nand_prefetch_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 14,
    parameter int CS_W  = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   nand_valid,
    input logic                   nand_ready,
    input logic [CS_W-1:0]        nand_cs,
    input logic                   busy,
    input logic [$clog2(DEPTH):0] fifo_fill,
    input logic [CNT_W-1:0]       remain
);
    // R6: occupancy never exceeds the FIFO depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_fill) <= DEPTH);

    // R6: a full FIFO refuses NAND bytes
    a_r6_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fifo_fill) == DEPTH) |-> !nand_ready);

    // R9: an idle engine takes no bytes
    a_r9_idle_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !nand_ready);

    // R3: every accepted byte lowers the remaining count by one
    a_r3_remain_step: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_valid && nand_ready) |=> (remain == $past(remain) - CNT_W'(1)));

    // R3: without a handshake a running engine keeps its remaining count
    a_r3_remain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(nand_valid && nand_ready)) |=> $stable(remain));

    // R8: chip select cannot change during a run
    a_r8_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(nand_cs));

    // R7: finished run releases busy on the next cycle
    a_r7_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (remain == '0) && (fifo_fill == '0)) |=> !busy);
endmodule

bind nand_prefetch nand_prefetch_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CS_W(CS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nand_valid (nand_valid),
    .nand_ready (nand_ready),
    .nand_cs    (nand_cs),
    .busy       (busy),
    .fifo_fill  (fifo_fill),
    .remain     (remain)
);

// File: tb/nand_prefetch_bench.sv
`timescale 1ns/100ps
module nand_prefetch_bench;
    localparam int A_CFG = 0, A_CNT = 1, A_CTRL = 2, A_STAT = 3, A_DATA = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        nand_valid = 1'b0;
    logic [7:0]  nand_data = '0;
    logic        nand_ready;
    logic [2:0]  nand_cs;
    logic        busy;
    logic [6:0]  fifo_fill;
    logic [13:0] remain;
    logic        thr_hit;

    int checks = 0;
    int fails  = 0;
    int seq    = 0;   // next byte index offered on the NAND side
    int rdseq  = 0;   // next byte index expected by the host

    always #2.5 clk = ~clk;

    nand_prefetch u_nand_prefetch (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nand_valid(nand_valid), .nand_data(nand_data), .nand_ready(nand_ready),
        .nand_cs(nand_cs), .busy(busy), .fifo_fill(fifo_fill), .remain(remain),
        .thr_hit(thr_hit)
    );

    function automatic logic [7:0] pat(int i);
        return 8'(i * 37 + 11);
    endfunction

    function automatic logic [31:0] cfgw(bit wpost, bit en, int thr, int cs);
        return (32'(cs) << 24) | (32'(thr) << 8) | (32'(en) << 7) | 32'(wpost);
    endfunction

    function automatic logic [31:0] statw(int fill, int rem);
        return (32'(fill) << 24) | 32'(rem);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(a); reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic feed(int n);
        for (int i = 0; i < n; ) begin
            @(negedge clk);
            nand_valid = 1'b1;
            nand_data  = pat(seq);
            #1;
            if (nand_ready) begin
                seq++;
                i++;
            end
        end
        @(negedge clk);
        nand_valid = 1'b0;
    endtask

    task automatic drain(string req, int words);
        logic [31:0] d;
        for (int w = 0; w < words; w++) begin
            rd(A_DATA, d);
            chk(req, d, {pat(rdseq+3), pat(rdseq+2), pat(rdseq+1), pat(rdseq)});
            rdseq += 4;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 busy", 32'(busy), 0);
        chk("R1 nand_ready", 32'(nand_ready), 0);
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_CFG, d);  chk("R1 cfg", d, 0);
        rd(A_CNT, d);  chk("R1 count", d, 0);
        rd(A_STAT, d); chk("R1 status", d, 0);
    endtask

    task automatic t_cfg_limit;
        logic [31:0] d;
        wr(A_CFG, cfgw(0, 1, 65, 2));
        rd(A_CFG, d); chk("R2 threshold 65 refused", d, 0);
        wr(A_CFG, cfgw(0, 1, 64, 2));
        rd(A_CFG, d); chk("R2 threshold 64 taken", d, cfgw(0, 1, 64, 2));
    endtask

    task automatic t_start_gate;
        wr(A_CNT, 8);
        wr(A_CFG, cfgw(1, 1, 4, 1));
        wr(A_CTRL, 1);
        @(negedge clk); chk("R9 write-post start ignored", 32'(busy), 0);
        wr(A_CFG, cfgw(0, 0, 4, 1));
        wr(A_CTRL, 1);
        @(negedge clk); chk("R9 disabled start ignored", 32'(busy), 0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        wr(A_CFG, cfgw(0, 1, 4, 5));
        wr(A_CNT, 8);
        wr(A_CTRL, 1);
        @(negedge clk);
        chk("R9 start", 32'(busy), 1);
        chk("R8 chip select", 32'(nand_cs), 5);
        feed(8);
        rd(A_STAT, d); chk("R3 status after 8 bytes", d, statw(8, 0));
        chk("R6 ready low when count spent", 32'(nand_ready), 0);
        drain("R4 little-endian word", 2);
        repeat (2) @(negedge clk);
        chk("R7 auto clear", 32'(busy), 0);
        rd(A_CTRL, d); chk("R7 control reads 0", d, 0);
    endtask

    task automatic t_underflow_abort;
        logic [31:0] d;
        wr(A_CFG, cfgw(0, 1, 0, 3));
        wr(A_CNT, 6);
        wr(A_CTRL, 1);
        feed(2);
        rd(A_DATA, d); chk("R5 short read returns 0", d, 0);
        rd(A_STAT, d); chk("R5 fill kept", d, statw(2, 4));
        feed(4);
        drain("R4 word", 1);
        repeat (3) @(negedge clk);
        chk("R7 stays busy with leftover bytes", 32'(busy), 1);
        wr(A_CTRL, 0);
        @(negedge clk);
        chk("R10 abort busy", 32'(busy), 0);
        chk("R10 abort fill", 32'(fifo_fill), 0);
        chk("R10 abort ready", 32'(nand_ready), 0);
        rdseq = seq;
    endtask

    task automatic t_running;
        logic [31:0] d;
        wr(A_CFG, cfgw(0, 1, 8, 1));
        wr(A_CNT, 40);
        wr(A_CTRL, 1);
        feed(7);
        chk("R11 below threshold", 32'(thr_hit), 0);
        feed(1);
        chk("R11 at threshold", 32'(thr_hit), 1);
        wr(A_CFG, cfgw(0, 1, 2, 6));
        rd(A_CFG, d); chk("R8 cfg write ignored while busy", d, cfgw(0, 1, 8, 1));
        chk("R8 chip select held", 32'(nand_cs), 1);
        wr(A_CNT, 3);
        rd(A_STAT, d); chk("R8 count write ignored while busy", d, statw(8, 32));
        feed(32);
        drain("R4 words", 10);
        repeat (2) @(negedge clk);
        chk("R7 auto clear", 32'(busy), 0);
    endtask

    task automatic t_full;
        logic [31:0] d;
        wr(A_CFG, cfgw(0, 1, 64, 0));
        wr(A_CNT, 100);
        wr(A_CTRL, 1);
        feed(64);
        chk("R6 ready low when full", 32'(nand_ready), 0);
        chk("R11 threshold 64 hit", 32'(thr_hit), 1);
        rd(A_STAT, d); chk("R6 status when full", d, statw(64, 36));
        @(negedge clk);
        nand_valid = 1'b1; nand_data = pat(seq);
        repeat (5) @(negedge clk);
        nand_valid = 1'b0;
        rd(A_STAT, d); chk("R6 stalled bytes dropped", d, statw(64, 36));
        drain("R4 words after full", 9);
        feed(36);
        rd(A_STAT, d); chk("R3 status refilled", d, statw(64, 0));
        drain("R4 words wrap", 16);
        repeat (2) @(negedge clk);
        chk("R7 auto clear", 32'(busy), 0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_limit();
        t_start_gate();
        t_basic();
        t_underflow_abort();
        t_running();
        t_full();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule